// File: doc/BRIEF.md
# Sampling-Rate Classifier

This block tells which audio sampling rate is present on an incoming frame-rate clock. It runs entirely on a fixed 12.288 MHz measurement clock. The frame-rate clock passes through a two-flop synchronizer, and the block counts measurement-clock cycles from one rising edge to the next. Each count is placed in one of seven narrow windows, one for each supported rate from 32 kHz to 192 kHz, or it is called "other".

The outputs are a 2-bit base-rate code and two family flags, one for double rates and one for quadruple rates. Both flags read low unless the rate is in that family. A new class reaches the outputs only after four consecutive measurements agree, so a single stray period cannot disturb downstream logic. If the frame-rate clock stops, a counter limit produces "other" measurements, and these settle the outputs to the unknown-rate state.

Top module: `fs_rate_detect`

## Requirements
- R1: After reset, and until a class has been confirmed, rate_code is 01 and dbl_rate and quad_rate are both 0.
- R2: A period of 377 to 391 reference cycles (32 kHz) confirms as rate_code 11 with both flags 0.
- R3: A period of 274 to 284 reference cycles (44.1 kHz) confirms as rate_code 00 with both flags 0.
- R4: A period of 251 to 261 reference cycles (48 kHz) confirms as rate_code 10 with both flags 0, and this includes both window edges.
- R5: A period of 137 to 141 cycles (88.2 kHz) or 126 to 130 cycles (96 kHz) confirms as rate_code 01 with dbl_rate 1 and quad_rate 0.
- R6: A period of 69 to 71 cycles (176.4 kHz) or 63 to 65 cycles (192 kHz) confirms as rate_code 01 with dbl_rate 0 and quad_rate 1.
- R7: A period that falls in no window, including a count just outside a window edge, confirms as rate_code 01 with both flags 0.
- R8: The outputs take a new class only after four consecutive measurements of that class. Three or fewer matching measurements, or one differing period inside a stable stream, leave the outputs unchanged.
- R9: When 512 reference cycles pass without a rising edge, the block counts one "other" measurement and restarts counting. A stalled input therefore reaches the R7 state after four such intervals. The first edge after a stall only restarts the measurement.
- R10: dbl_rate and quad_rate are never both 1, and either flag being 1 implies rate_code 01.
- R11: Only the spacing of rising edges is measured, so the high-time of the input has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_meas | input | 1 | 12.288 MHz measurement clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk_meas |
| smp_clk | input | 1 | Asynchronous frame-rate clock to classify |
| rate_code | output | 2 | Base-rate code: 00 = 44.1k, 10 = 48k, 11 = 32k, 01 = other |
| dbl_rate | output | 1 | High for 88.2/96 kHz |
| quad_rate | output | 1 | High for 176.4/192 kHz |

## Verification
A corrupted period counter appears at the ports as a wrong class, or as a missing class change, within about five frame periods. A wrong confirmation run count is visible too: the outputs switch too early after a short burst of a different rate, or too late after a rate change. A fault in the stall handling shows up only after roughly 2000 reference cycles with no edge, so the stall is held long enough to look at both sides of the fourth overflow. Every output transition is matched against an ordered list of expected codes, which catches any spurious change as well as any missing one.

// File: rtl/fsd_pkg.sv
package fsd_pkg;

    typedef enum logic [2:0] {
        CL_32   = 3'd0,
        CL_441  = 3'd1,
        CL_48   = 3'd2,
        CL_882  = 3'd3,
        CL_96   = 3'd4,
        CL_1764 = 3'd5,
        CL_192  = 3'd6,
        CL_OTHER = 3'd7
    } rate_cls_e;

    localparam int NUM_CLS = 7;

    // Sampling rate in Hz for each class index 0..6
    function automatic int cls_rate_hz(input int idx);
        case (idx)
            0: return 32000;
            1: return 44100;
            2: return 48000;
            3: return 88200;
            4: return 96000;
            5: return 176400;
            default: return 192000;
        endcase
    endfunction

    // Rounded reference cycles per sample period
    function automatic int nominal_cnt(input int ref_hz, input int idx);
        int r;
        r = cls_rate_hz(idx);
        return (ref_hz + r / 2) / r;
    endfunction

    function automatic int window_tol(input int ref_hz, input int idx, input int pct);
        int t;
        t = (nominal_cnt(ref_hz, idx) * pct) / 100;
        return (t < 1) ? 1 : t;
    endfunction

endpackage

// File: rtl/fsd_sync.sv
module fsd_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    typedef struct packed {
        logic meta;
        logic sync;
        logic prev;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = async_in;
        st_d.sync = st_q.meta;
        st_d.prev = st_q.sync;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise = st_q.sync & ~st_q.prev;

endmodule

// File: rtl/fsd_period.sv
module fsd_period #(
    parameter int OVF_CYC = 512,
    localparam int CW = $clog2(OVF_CYC + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rise,
    output logic          meas_vld,
    output logic          meas_ovf,
    output logic [CW-1:0] meas_cnt
);
    localparam logic [CW-1:0] LIMIT = CW'(OVF_CYC);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          armed;
        logic          vld;
        logic          ovf;
        logic [CW-1:0] mcnt;
    } per_st_t;

    per_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        st_d.ovf = 1'b0;
        if (rise) begin
            // an edge closes a period only when the previous edge was seen
            st_d.vld   = st_q.armed;
            st_d.mcnt  = st_q.cnt;
            st_d.armed = 1'b1;
            st_d.cnt   = CW'(1);
        end else if (st_q.cnt == LIMIT) begin
            st_d.vld   = 1'b1;
            st_d.ovf   = 1'b1;
            st_d.mcnt  = st_q.cnt;
            st_d.armed = 1'b0;
            st_d.cnt   = CW'(1);
        end else begin
            st_d.cnt = st_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.cnt <= CW'(1);
        end else begin
            st_q <= st_d;
        end
    end

    assign meas_vld = st_q.vld;
    assign meas_ovf = st_q.ovf;
    assign meas_cnt = st_q.mcnt;

    // R9: counter never runs past the stall limit
    a_r9_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LIMIT);
    // R9: a stall measurement follows a cycle without an edge
    a_r9_ovf_no_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_vld && meas_ovf) |-> !$past(rise));

endmodule

// File: rtl/fsd_window.sv
module fsd_window
    import fsd_pkg::*;
#(
    parameter int REF_HZ  = 12288000,
    parameter int TOL_PCT = 2,
    parameter int CW      = 10
) (
    input  logic [CW-1:0] cnt,
    input  logic          ovf,
    output rate_cls_e     cls
);
    logic [NUM_CLS-1:0] hit;

    for (genvar i = 0; i < NUM_CLS; i++) begin : g_win
        localparam int NOM = nominal_cnt(REF_HZ, i);
        localparam int TOL = window_tol(REF_HZ, i, TOL_PCT);
        localparam int LO  = NOM - TOL;
        localparam int HI  = NOM + TOL;
        assign hit[i] = (32'(cnt) >= LO) && (32'(cnt) <= HI);
    end

    always_comb begin
        cls = CL_OTHER;
        if (!ovf) begin
            for (int k = NUM_CLS - 1; k >= 0; k--) begin
                if (hit[k]) cls = rate_cls_e'(3'(k));
            end
        end
    end

    // R7: windows are disjoint, so at most one can match
    always_comb begin
        a_r7_one_window: assert ($onehot0(hit));
    end

endmodule

// File: rtl/fsd_confirm.sv
module fsd_confirm
    import fsd_pkg::*;
#(
    parameter int CONFIRM_N = 4,
    localparam int RW = $clog2(CONFIRM_N + 1)
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      meas_vld,
    input  rate_cls_e meas_cls,
    output rate_cls_e held_cls
);
    localparam logic [RW-1:0] RUN_MAX = RW'(CONFIRM_N);

    typedef struct packed {
        rate_cls_e     cand;
        logic [RW-1:0] run;
        rate_cls_e     held;
    } cf_st_t;

    cf_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (meas_vld) begin
            if (meas_cls == st_q.cand) begin
                if (st_q.run != RUN_MAX) st_d.run = st_q.run + RW'(1);
            end else begin
                st_d.cand = meas_cls;
                st_d.run  = RW'(1);
            end
            if (st_d.run == RUN_MAX) st_d.held = st_d.cand;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cand <= CL_OTHER;
            st_q.run  <= '0;
            st_q.held <= CL_OTHER;
        end else begin
            st_q <= st_d;
        end
    end

    assign held_cls = st_q.held;

    // R8: the held class moves only on a measurement
    a_r8_move_on_meas: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.held) |-> $past(meas_vld));
    // R8: the held class moves only to a fully confirmed candidate
    a_r8_move_confirmed: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.held) |-> (st_q.run == RUN_MAX && st_q.held == st_q.cand));

endmodule

// File: rtl/fs_rate_detect.sv
module fs_rate_detect
    import fsd_pkg::*;
#(
    parameter int REF_HZ    = 12288000,
    parameter int TOL_PCT   = 2,
    parameter int OVF_CYC   = 512,
    parameter int CONFIRM_N = 4
) (
    input  logic       clk_meas,
    input  logic       rst_n,
    input  logic       smp_clk,
    output logic [1:0] rate_code,
    output logic       dbl_rate,
    output logic       quad_rate
);
    localparam int CW = $clog2(OVF_CYC + 1);

    logic          rise;
    logic          meas_vld;
    logic          meas_ovf;
    logic [CW-1:0] meas_cnt;
    rate_cls_e     meas_cls;
    rate_cls_e     held_cls;

    fsd_sync u_sync (
        .clk      (clk_meas),
        .rst_n    (rst_n),
        .async_in (smp_clk),
        .rise     (rise)
    );

    fsd_period #(.OVF_CYC(OVF_CYC)) u_period (
        .clk      (clk_meas),
        .rst_n    (rst_n),
        .rise     (rise),
        .meas_vld (meas_vld),
        .meas_ovf (meas_ovf),
        .meas_cnt (meas_cnt)
    );

    fsd_window #(.REF_HZ(REF_HZ), .TOL_PCT(TOL_PCT), .CW(CW)) u_window (
        .cnt (meas_cnt),
        .ovf (meas_ovf),
        .cls (meas_cls)
    );

    fsd_confirm #(.CONFIRM_N(CONFIRM_N)) u_confirm (
        .clk      (clk_meas),
        .rst_n    (rst_n),
        .meas_vld (meas_vld),
        .meas_cls (meas_cls),
        .held_cls (held_cls)
    );

    typedef struct packed {
        logic [1:0] code;
        logic       dbl;
        logic       quad;
    } out_st_t;

    out_st_t out_d, out_q;

    always_comb begin
        out_d = '{code: 2'b01, dbl: 1'b0, quad: 1'b0};
        case (held_cls)
            CL_32:           out_d.code = 2'b11;
            CL_441:          out_d.code = 2'b00;
            CL_48:           out_d.code = 2'b10;
            CL_882, CL_96:   out_d.dbl  = 1'b1;
            CL_1764, CL_192: out_d.quad = 1'b1;
            default:         out_d.code = 2'b01;
        endcase
    end

    always_ff @(posedge clk_meas) begin
        if (!rst_n) out_q <= '{code: 2'b01, dbl: 1'b0, quad: 1'b0};
        else        out_q <= out_d;
    end

    assign rate_code = out_q.code;
    assign dbl_rate  = out_q.dbl;
    assign quad_rate = out_q.quad;

    // R10: the family flags exclude each other
    a_r10_flags_excl: assert property (@(posedge clk_meas) disable iff (!rst_n)
        !(dbl_rate && quad_rate));
    // R10: a family flag only appears alongside the "other" base code
    a_r10_flag_code: assert property (@(posedge clk_meas) disable iff (!rst_n)
        (dbl_rate || quad_rate) |-> rate_code == 2'b01);
    // R8: the ports follow the held class one cycle later
    a_r8_port_lag: assert property (@(posedge clk_meas) disable iff (!rst_n)
        !$stable(rate_code) |-> !$stable($past(held_cls)) || $past(held_cls) != held_cls
            || $past(!$stable(held_cls)));

endmodule

// File: tb/fs_rate_detect_tb_top.sv
module fs_rate_detect_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       smp = 1'b0;
    logic [1:0] code;
    logic       dbl, quad;

    int total = 0;
    int bad   = 0;
    logic started = 1'b0;
    logic done = 1'b0;

    // expected port values packed as {code, dbl, quad}
    localparam logic [3:0] E_OTHER = 4'b0100;
    localparam logic [3:0] E_32    = 4'b1100;
    localparam logic [3:0] E_441   = 4'b0000;
    localparam logic [3:0] E_48    = 4'b1000;
    localparam logic [3:0] E_X2    = 4'b0110;
    localparam logic [3:0] E_X4    = 4'b0101;

    logic [3:0] expq[$];
    logic [3:0] cur_exp = E_OTHER;
    logic [3:0] prev_obs = E_OTHER;

    always #4 clk = ~clk;

    fs_rate_detect dut_i (
        .clk_meas  (clk),
        .rst_n     (rst_n),
        .smp_clk   (smp),
        .rate_code (code),
        .dbl_rate  (dbl),
        .quad_rate (quad)
    );

    function automatic logic [3:0] obs();
        return {code, dbl, quad};
    endfunction

    task automatic check(input string tag, input logic [3:0] got, input logic [3:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %b expected %b at %0t", tag, got, exp, $time);
        end
    endtask

    // monitor: every output transition must match the next expected item
    always @(negedge clk) begin
        if (started && !done) begin
            if (obs() !== prev_obs) begin
                if (expq.size() == 0) begin
                    check("R8 unexpected change", obs(), prev_obs);
                end else begin
                    check("scoreboard transition", obs(), expq.pop_front());
                end
                prev_obs = obs();
            end
        end
    end

    task automatic drive(input int p, input int hi, input int n);
        for (int k = 0; k < n; k++) begin
            smp = 1'b1;
            repeat (hi) @(negedge clk);
            smp = 1'b0;
            repeat (p - hi) @(negedge clk);
        end
    endtask

    // drive a segment; expect the ports to settle on e
    task automatic seg(input int p, input int n, input logic [3:0] e);
        if (e !== cur_exp) begin
            expq.push_back(e);
            cur_exp = e;
        end
        drive(p, p / 2, n);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        check("R1 reset state", obs(), E_OTHER);
        rst_n = 1'b1;
        started = 1'b1;
        repeat (20) @(negedge clk);
        check("R1 idle after reset", obs(), E_OTHER);

        // R8: from reset, four periods give only three measurements
        expq.push_back(E_48); cur_exp = E_48;
        drive(256, 128, 4);
        check("R8 not yet confirmed", obs(), E_OTHER);
        drive(256, 128, 4);
        check("R4 48k", obs(), E_48);

        seg(384, 6, E_32);   check("R2 32k", obs(), cur_exp);
        seg(279, 6, E_441);  check("R3 44.1k", obs(), cur_exp);
        seg(128, 6, E_X2);   check("R5 96k", obs(), cur_exp);
        seg(139, 6, E_X2);   check("R5 88.2k", obs(), cur_exp);
        seg(64, 6, E_X4);    check("R6 192k", obs(), cur_exp);
        seg(70, 6, E_X4);    check("R6 176.4k", obs(), cur_exp);
        seg(300, 6, E_OTHER); check("R7 no window", obs(), cur_exp);
        seg(251, 6, E_48);   check("R4 lower edge", obs(), cur_exp);
        seg(261, 6, E_48);   check("R4 upper edge", obs(), cur_exp);
        seg(250, 6, E_OTHER); check("R7 below 48k window", obs(), cur_exp);
        seg(391, 6, E_32);   check("R2 upper edge", obs(), cur_exp);
        seg(392, 6, E_OTHER); check("R7 above 32k window", obs(), cur_exp);

        // R8: single stray period and a short burst are ignored
        seg(256, 6, E_48);
        drive(300, 150, 1);
        check("R8 stray period", obs(), E_48);
        seg(256, 6, E_48);
        drive(128, 64, 3);
        check("R8 short burst", obs(), E_48);
        seg(256, 6, E_48);
        check("R8 stable after burst", obs(), E_48);

        // R11: narrow high pulse, only rising-edge spacing matters
        expq.push_back(E_441); cur_exp = E_441;
        drive(279, 5, 6);
        check("R11 narrow pulse 44.1k", obs(), E_441);

        // R9: stall; overflows near 232/744/1256/1768 cycles into the hold
        expq.push_back(E_OTHER); cur_exp = E_OTHER;
        repeat (1500) @(negedge clk);
        check("R9 three stalls not enough", obs(), E_441);
        repeat (500) @(negedge clk);
        check("R9 stall to other", obs(), E_OTHER);

        // R9: recovery, first edge only re-arms
        seg(64, 6, E_X4);    check("R6 recovery 192k", obs(), cur_exp);

        repeat (10) @(negedge clk);
        done = 1'b1;
        total++;
        if (expq.size() != 0) begin
            bad++;
            $display("FAIL R8 missing transitions: got %0d pending expected 0", expq.size());
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule